// File: doc/BRIEF.md
# Pipelined Rotating-Priority Bus Arbiter

This block decides which of several nodes may place the next command on a shared address/command bus. Each node owns one request line. One node, the I/O node, also owns two extra lines: an urgent line that beats every other request, and a background line that only wins when nothing else is asking. The bus runs a three-step pipeline. A request cycle samples the request lines. The arbitration cycle after it picks a winner. In the cycle after that, the winner drives the bus. On a busy bus a request cycle comes every second cycle, so a new command can start at most once per two cycles.

Nodes in the ordinary pool are ranked by a rotating order. After a real command, the winner drops to the bottom of that order, which lets every persistent requester climb to the top in time. The arbiter watches a command-type input during the drive cycle. If that input flags a no-op, the order stays as it was. A no-op is what a node issues when it asked early and then found it had nothing to send.

Top module: `bus_arbiter`

## Requirements
- R1: `phase_o` reads 2'b00 (idle) when no request line is asserted and no arbitration is in progress. It reads 2'b01 (request) in any cycle that is not an arbitration cycle and has at least one request line asserted.
- R2: The cycle after a request cycle always reads 2'b10 (arbitration). An arbitration cycle is never followed by another arbitration cycle. With requests held, request and arbitration cycles alternate.
- R3: `grant_o` is zero or one-hot. It is non-zero only in the cycle right after an arbitration cycle, and only for that one cycle.
- R4: A request line raised during an arbitration cycle plays no part in that arbitration, even if its node ranks higher than the nodes sampled in the preceding request cycle.
- R5: Among pool requests sampled together, the node with the highest current rank wins. After reset the rank equals the node index, so node N_NODES-1 is highest and node 0 is lowest.
- R6: When a pool node wins and `cmd_noop_i` is low in its grant cycle, that node becomes the lowest rank. Every node that ranked below it moves up by one. All other nodes keep their rank.
- R7: If `cmd_noop_i` is high in the grant cycle, the rank order does not change.
- R8: The I/O urgent line `io_hi_i` outranks all pool requests. Its win grants bit IO_NODE and leaves the rank order unchanged.
- R9: The I/O background line `io_lo_i` wins only when no pool request and no urgent request were sampled. Its win grants bit IO_NODE and leaves the rank order unchanged.
- R10: With every pool line held high on a busy bus, each node is granted exactly once in any N_NODES consecutive grants.
- R11: While reset is asserted, `grant_o` is zero and the phase reads idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_NODES | One pool request line per node |
| io_hi_i | input | 1 | I/O node urgent request, top priority |
| io_lo_i | input | 1 | I/O node background request, bottom priority |
| cmd_noop_i | input | 1 | Winner's command is a no-op; valid in the grant cycle |
| grant_o | output | N_NODES | One-hot grant, valid in the drive cycle |
| phase_o | output | 2 | Bus cycle kind: 00 idle, 01 request, 10 arbitration |

## Verification
The phase output is combinational on the current request lines and one state bit, so the bench reads it a little after driving the inputs in the same cycle. The grant is due two clock edges after the request cycle: one edge into arbitration, and one more into the drive cycle. The bench samples it on the second falling edge after raising the requests. A rank change takes effect on the edge that ends the grant cycle, so the bench commits its own copy of the order only after that edge. It judges the result by the winner of the next round. Every expected winner comes from an ordered list in the bench that is kept lowest-first and rotated by moving the winner to the front.

// File: rtl/bus_arbiter_pkg.sv
package bus_arbiter_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_REQ  = 2'b01,
    PH_ARB  = 2'b10
  } bus_phase_e;

  // Rank of one node after a committed win by the node whose rank is win_rank.
  function automatic int unsigned next_rank(input int unsigned cur,
                                            input int unsigned win_rank,
                                            input bit          is_winner);
    if (is_winner)         return 0;
    if (cur < win_rank)    return cur + 1;
    return cur;
  endfunction

endpackage

// File: rtl/bus_phase_ctrl.sv
module bus_phase_ctrl
  import bus_arbiter_pkg::*;
#(
  parameter int N_NODES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_NODES-1:0] req_i,
  input  logic               io_hi_i,
  input  logic               io_lo_i,
  output bus_phase_e         phase,
  output logic               arb_cycle,
  output logic [N_NODES-1:0] samp_req,
  output logic               samp_hi,
  output logic               samp_lo
);
  timeunit 1ns; timeprecision 1ps;

  logic arb_q;
  logic any_req;
  logic req_cycle;

  assign any_req   = (|req_i) | io_hi_i | io_lo_i;
  assign req_cycle = !arb_q && any_req;
  assign arb_cycle = arb_q;

  always_comb begin
    if (arb_q)        phase = PH_ARB;
    else if (any_req) phase = PH_REQ;
    else              phase = PH_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arb_q    <= 1'b0;
      samp_req <= '0;
      samp_hi  <= 1'b0;
      samp_lo  <= 1'b0;
    end else begin
      arb_q <= req_cycle;
      if (req_cycle) begin
        samp_req <= req_i;
        samp_hi  <= io_hi_i;
        samp_lo  <= io_lo_i;
      end
    end
  end

endmodule

// File: rtl/bus_win_pick.sv
module bus_win_pick #(
  parameter int N_NODES = 8,
  parameter int IO_NODE = 5,
  localparam int IW = $clog2(N_NODES)
) (
  input  logic [N_NODES-1:0]         samp_req,
  input  logic                       samp_hi,
  input  logic                       samp_lo,
  input  logic [N_NODES-1:0][IW-1:0] rank,
  output logic                       win_valid,
  output logic [IW-1:0]              win_idx,
  output logic                       win_pool
);
  timeunit 1ns; timeprecision 1ps;

  logic          found;
  logic [IW-1:0] best_idx;
  logic [IW-1:0] best_rank;

  always_comb begin
    found     = 1'b0;
    best_idx  = '0;
    best_rank = '0;
    for (int i = 0; i < N_NODES; i++) begin
      if (samp_req[i] && (!found || rank[i] > best_rank)) begin
        found     = 1'b1;
        best_idx  = IW'(i);
        best_rank = rank[i];
      end
    end
  end

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_pool  = 1'b0;
    if (samp_hi) begin
      win_valid = 1'b1;
      win_idx   = IW'(IO_NODE);
    end else if (found) begin
      win_valid = 1'b1;
      win_idx   = best_idx;
      win_pool  = 1'b1;
    end else if (samp_lo) begin
      win_valid = 1'b1;
      win_idx   = IW'(IO_NODE);
    end
  end

endmodule

// File: rtl/bus_rank_file.sv
module bus_rank_file
  import bus_arbiter_pkg::*;
#(
  parameter int N_NODES = 8,
  localparam int IW = $clog2(N_NODES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       upd_en,
  input  logic [IW-1:0]              upd_idx,
  output logic [N_NODES-1:0][IW-1:0] rank
);
  timeunit 1ns; timeprecision 1ps;

  logic [IW-1:0] win_rank;
  assign win_rank = rank[upd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_NODES; i++) rank[i] <= IW'(i);
    end else if (upd_en) begin
      for (int i = 0; i < N_NODES; i++)
        rank[i] <= IW'(next_rank(int'(rank[i]), int'(win_rank), (IW'(i) == upd_idx)));
    end
  end

endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
  import bus_arbiter_pkg::*;
#(
  parameter int N_NODES = 8,
  parameter int IO_NODE = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_NODES-1:0] req_i,
  input  logic               io_hi_i,
  input  logic               io_lo_i,
  input  logic               cmd_noop_i,
  output logic [N_NODES-1:0] grant_o,
  output logic [1:0]         phase_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam int IW = $clog2(N_NODES);

  bus_phase_e                 phase;
  logic                       arb_cycle;
  logic [N_NODES-1:0]         samp_req;
  logic                       samp_hi;
  logic                       samp_lo;
  logic                       win_valid;
  logic [IW-1:0]              win_idx;
  logic                       win_pool;
  logic [N_NODES-1:0][IW-1:0] rank;
  logic [N_NODES-1:0]         grant_q;
  logic [IW-1:0]              win_idx_q;
  logic                       win_pool_q;
  logic                       drive_cycle;
  logic                       rank_commit;

  function automatic logic [N_NODES-1:0] to_onehot(input logic [IW-1:0] idx);
    return N_NODES'(1) << idx;
  endfunction

  bus_phase_ctrl #(.N_NODES(N_NODES)) u_phase (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .io_hi_i(io_hi_i), .io_lo_i(io_lo_i),
    .phase(phase), .arb_cycle(arb_cycle), .samp_req(samp_req),
    .samp_hi(samp_hi), .samp_lo(samp_lo)
  );

  bus_win_pick #(.N_NODES(N_NODES), .IO_NODE(IO_NODE)) u_pick (
    .samp_req(samp_req), .samp_hi(samp_hi), .samp_lo(samp_lo), .rank(rank),
    .win_valid(win_valid), .win_idx(win_idx), .win_pool(win_pool)
  );

  assign drive_cycle = |grant_q;
  assign rank_commit = drive_cycle && win_pool_q && !cmd_noop_i;

  bus_rank_file #(.N_NODES(N_NODES)) u_rank (
    .clk(clk), .rst_n(rst_n), .upd_en(rank_commit), .upd_idx(win_idx_q), .rank(rank)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q    <= '0;
      win_idx_q  <= '0;
      win_pool_q <= 1'b0;
    end else begin
      grant_q    <= (arb_cycle && win_valid) ? to_onehot(win_idx) : '0;
      win_idx_q  <= win_idx;
      win_pool_q <= arb_cycle && win_valid && win_pool;
    end
  end

  assign grant_o = grant_q;
  assign phase_o = phase;

endmodule

// File: rtl/bus_arbiter_chk.sv
module bus_arbiter_chk #(
  parameter int N_NODES = 8,
  parameter int IO_NODE = 5,
  localparam int IW = $clog2(N_NODES)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [1:0]                 phase_o,
  input logic [N_NODES-1:0]         grant_o,
  input logic                       cmd_noop_i,
  input logic                       samp_hi,
  input logic                       win_pool_q,
  input logic [N_NODES-1:0][IW-1:0] rank
);
  timeunit 1ns; timeprecision 1ps;

  localparam logic [N_NODES-1:0] IO_MASK = N_NODES'(1) << IO_NODE;

  p_arb_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o == 2'b01 |=> phase_o == 2'b10);

  p_no_double_arb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o == 2'b10 |=> phase_o != 2'b10);

  p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  p_grant_after_arb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o != '0 |-> $past(phase_o) == 2'b10);

  p_grant_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o != '0 |=> grant_o == '0);

  p_noop_keeps_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0 && cmd_noop_i) |=> $stable(rank));

  p_urgent_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'b10 && samp_hi) |=> grant_o == IO_MASK);

  p_fixed_keeps_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0 && !win_pool_q) |=> $stable(rank));

endmodule

bind bus_arbiter bus_arbiter_chk #(.N_NODES(N_NODES), .IO_NODE(IO_NODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase_o(phase_o), .grant_o(grant_o),
  .cmd_noop_i(cmd_noop_i), .samp_hi(samp_hi), .win_pool_q(win_pool_q), .rank(rank)
);

// File: tb/bus_arbiter_bench.sv
module bus_arbiter_bench;
  timeunit 1ns; timeprecision 1ps;

  localparam int N  = 8;
  localparam int IO = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req_i = '0;
  logic         io_hi_i = 1'b0;
  logic         io_lo_i = 1'b0;
  logic         cmd_noop_i = 1'b0;
  logic [N-1:0] grant_o;
  logic [1:0]   phase_o;

  int vecs = 0;
  int miss = 0;
  int ord[N];   // lowest rank first

  always #4 clk = ~clk;

  bus_arbiter #(.N_NODES(N), .IO_NODE(IO)) u_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .io_hi_i(io_hi_i), .io_lo_i(io_lo_i),
    .cmd_noop_i(cmd_noop_i), .grant_o(grant_o), .phase_o(phase_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int model_pick(input logic [N-1:0] m, input bit hi, input bit lo);
    if (hi) return IO;
    for (int p = N - 1; p >= 0; p--) if (m[ord[p]]) return ord[p];
    if (lo) return IO;
    return -1;
  endfunction

  task automatic model_commit(input int w);
    int pos = 0;
    for (int p = 0; p < N; p++) if (ord[p] == w) pos = p;
    for (int p = pos; p > 0; p--) ord[p] = ord[p-1];
    ord[0] = w;
  endtask

  task automatic round(input string tag, input logic [N-1:0] m, input bit hi, input bit lo,
                       input logic [N-1:0] late, input bit noop);
    int w;
    bit pool;
    logic [N-1:0] exp;
    w    = model_pick(m, hi, lo);
    pool = !hi && (m != '0);
    exp  = (w < 0) ? '0 : (N'(1) << w);
    @(negedge clk); req_i = m; io_hi_i = hi; io_lo_i = lo;
    #1 check({tag, " R1 request phase"}, 32'(phase_o), 32'h1);
    @(negedge clk); req_i = late; io_hi_i = 1'b0; io_lo_i = 1'b0;
    #1 check({tag, " R2 arbitration phase"}, 32'(phase_o), 32'h2);
    @(negedge clk); req_i = '0; cmd_noop_i = noop;
    #1 check({tag, " R3 grant"}, 32'(grant_o), 32'(exp));
    check({tag, " R1 idle phase"}, 32'(phase_o), 32'h0);
    @(negedge clk); cmd_noop_i = 1'b0;
    #1 check({tag, " R3 grant one cycle"}, 32'(grant_o), 32'h0);
    if (pool && !noop) model_commit(w);
  endtask

  task automatic t_reset;
    check("R11 reset grant", 32'(grant_o), 32'h0);
    check("R11 reset phase", 32'(phase_o), 32'h0);
  endtask

  task automatic t_single_and_order;
    round("R5 single", 8'h08, 0, 0, '0, 0);
    round("R5 R6 pair", 8'h81, 0, 0, '0, 0);
    round("R6 after rotate", 8'h81, 0, 0, '0, 0);
  endtask

  task automatic t_noop;
    round("R7 noop win", 8'h44, 0, 0, '0, 1);
    round("R7 same winner", 8'h44, 0, 0, '0, 0);
    round("R6 moved down", 8'h44, 0, 0, '0, 0);
  endtask

  task automatic t_late;
    round("R4 late ignored", 8'h02, 0, 0, 8'h80, 0);
  endtask

  task automatic t_io;
    round("R8 urgent", 8'hFF, 1, 0, '0, 0);
    round("R8 order kept", 8'hFF, 0, 0, '0, 0);
    round("R9 background loses", 8'h02, 0, 1, '0, 0);
    round("R9 background alone", 8'h00, 0, 1, '0, 0);
    round("R9 order kept", 8'hFF, 0, 0, '0, 0);
  endtask

  task automatic t_busy;
    logic [N-1:0] seen = '0;
    int w;
    @(negedge clk); req_i = '1;
    #1 check("R2 busy first request", 32'(phase_o), 32'h1);
    for (int r = 0; r < N; r++) begin
      @(negedge clk);
      #1 check("R2 busy arbitration", 32'(phase_o), 32'h2);
      @(negedge clk);
      #1 w = model_pick('1, 0, 0);
      check("R10 busy grant", 32'(grant_o), 32'(N'(1) << w));
      check("R2 busy request again", 32'(phase_o), 32'h1);
      seen |= grant_o;
      model_commit(w);
      if (r == N - 1) req_i = '0;
    end
    check("R10 every node served", 32'(seen), 32'(N'('1)));
    @(negedge clk);
    #1 check("R1 busy back to idle", 32'(phase_o), 32'h0);
  endtask

  initial begin
    for (int p = 0; p < N; p++) ord[p] = p;
    repeat (3) @(negedge clk);
    #1 t_reset();
    rst_n = 1'b1;
    t_single_and_order();
    t_noop();
    t_late();
    t_io();
    t_busy();
    t_single_and_order();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    #(8 * 20000);
    miss++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

endmodule